// File: doc/BRIEF.md
# Motor Line Soft Serial Link

This block runs half-duplex byte serial traffic over a single motor signal wire. Motor controllers can then be configured or reprogrammed through the same line that normally carries their drive pulses. When transmitting, it drives 8N1 frames onto the wire: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts a programmable number of clock ticks. For a baud rate B and clock frequency F, that number is F/B, which is the tick form of a bit time of 1,000,000/B microseconds.

The receiver does not sample the line at mid-bit. It watches for changes of the synchronised line level and counts the ticks elapsed since the start edge. From that count it computes a rounded bit index, (elapsed + half a bit) / bit time. Every bit position between the previous edge and the current one takes the level the line held before the current edge. At the stop-bit position the byte is complete. A rising edge while no byte is in progress is reported as a framing error. A stop position found low is reported as a receive timeout.

On the transmit side, the line is held driven at idle level for a short guard time after the last stop bit, and then released. A byte whose transmission runs past a cycle limit is aborted and flagged. The host chooses the direction with a mode input. While receive mode is selected, transmit requests are refused. While the block is driving the line, the receiver stays idle.

Top module: `motor_line_uart`

## Requirements
- R1: After a tx_start accepted at a clock edge, line_oe is high and line_out carries the start bit (0) from that edge on. Then come data bits 0 to 7 and the stop bit (1). Each of the ten bits lasts bit_ticks cycles.
- R2: tx_busy is high for the ten bit times of a frame. A tx_start that arrives while tx_busy is high is ignored, and the running frame keeps its original data.
- R3: When the stop bit ends, line_out stays driven high with line_oe high for GUARD_TICKS cycles, after which line_oe falls. A tx_start accepted during this guard starts the next frame at once.
- R4: If a frame has not finished TX_LIMIT cycles after it started, it is aborted. tx_fail pulses for one cycle, line_oe falls and tx_busy falls in that same cycle.
- R5: While rx_mode is 1, tx_start is ignored: line_oe stays 0 and tx_busy stays 0.
- R6: In receive mode, a frame on line_in produces a one-cycle rx_valid pulse, and rx_byte holds its eight data bits (bit 0 received first). This holds for back-to-back frames with a single stop bit.
- R7: A rising edge of line_in in receive mode with no byte in progress gives a one-cycle rx_frame_err pulse and no rx_valid.
- R8: If line_in is still low when the bit index reaches the stop position, rx_timeout pulses for one cycle and no rx_valid is produced.
- R9: The bit index is (elapsed + bit_ticks/2) / bit_ticks. A frame whose edges are displaced from nominal by less than half a bit time decodes correctly.
- R10: While rx_mode is 0, or while the block drives the line, activity on line_in produces no rx_valid, rx_frame_err or rx_timeout pulse.
- R11: After reset, line_oe is 0, line_out is 1, and tx_busy, tx_fail, rx_valid, rx_frame_err, rx_timeout and rx_byte are all 0. bit_ticks must be at least 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Byte to transmit |
| tx_start | input | 1 | Strobe: begin transmitting tx_data |
| bit_ticks | input | BT_W | Clock ticks per bit (at least 4) |
| rx_mode | input | 1 | 1 selects receive, 0 allows transmit |
| line_in | input | 1 | Level read from the motor line (asynchronous) |
| line_out | output | 1 | Level to drive onto the line |
| line_oe | output | 1 | Drive enable for the line |
| tx_busy | output | 1 | Frame in progress |
| tx_fail | output | 1 | One-cycle pulse: frame aborted by the cycle limit |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: rx_byte updated |
| rx_frame_err | output | 1 | One-cycle pulse: rising edge with no byte in progress |
| rx_timeout | output | 1 | One-cycle pulse: stop position found low |

## Verification
The checker evaluates relations that must hold on every cycle. These are: a busy frame always drives the line; a frame always opens with a low level; the guard always follows the end of a frame unless the frame was aborted; an abort releases the line; receive mode never lets the driver turn on; and no receive pulse appears while the line is driven or receive mode is off. Only the bench scenarios can show that bits come out in the right order and with the right duration. The same holds for decoding bytes from edge timing, including displaced edges and back-to-back frames, and for the exact cycles at which the guard ends and the abort occurs.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
  localparam int FRAME_BITS = 10;
  localparam int STOP_POS   = FRAME_BITS - 1;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GUARD} tx_state_t;
  typedef enum logic       {RX_WAIT, RX_BYTE}           rx_state_t;
endpackage

// File: rtl/mlu_sync.sv
module mlu_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mlu_tx.sv
module mlu_tx
  import mlu_pkg::*;
#(
  parameter int BT_W        = 16,
  parameter int TX_LIMIT    = 100000,
  parameter int GUARD_TICKS = 500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      data,
  input  logic [BT_W-1:0] bit_ticks,
  input  logic            inhibit,
  output logic            line_out,
  output logic            line_oe,
  output logic            busy,
  output logic            fail
);
  localparam int LIM_W = $clog2(TX_LIMIT + 1);
  localparam int GRD_W = $clog2(GUARD_TICKS + 1);

  tx_state_t              state;
  logic [FRAME_BITS-1:0]  shreg;
  logic [3:0]             bitn;
  logic [BT_W-1:0]        tick;
  logic [LIM_W-1:0]       tot;
  logic [GRD_W-1:0]       gcnt;
  logic                   go;

  assign go   = start && !inhibit && (state != TX_SEND);
  assign busy = (state == TX_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      shreg    <= '1;
      bitn     <= '0;
      tick     <= '0;
      tot      <= '0;
      gcnt     <= '0;
      line_out <= 1'b1;
      line_oe  <= 1'b0;
      fail     <= 1'b0;
    end else begin
      fail <= 1'b0;
      unique case (state)
        TX_IDLE, TX_GUARD: begin
          if (go) begin
            state    <= TX_SEND;
            shreg    <= {1'b1, data, 1'b0};
            line_out <= 1'b0;
            line_oe  <= 1'b1;
            bitn     <= '0;
            tick     <= '0;
            tot      <= '0;
          end else if (state == TX_GUARD) begin
            if (gcnt == GRD_W'(GUARD_TICKS - 1)) begin
              state   <= TX_IDLE;
              line_oe <= 1'b0;
            end else begin
              gcnt <= gcnt + GRD_W'(1);
            end
          end
        end
        TX_SEND: begin
          tot <= tot + LIM_W'(1);
          if (tot == LIM_W'(TX_LIMIT - 1)) begin
            fail     <= 1'b1;
            state    <= TX_IDLE;
            line_oe  <= 1'b0;
            line_out <= 1'b1;
          end else if (tick == bit_ticks - BT_W'(1)) begin
            tick <= '0;
            if (bitn == 4'(STOP_POS)) begin
              state    <= TX_GUARD;
              gcnt     <= '0;
              line_out <= 1'b1;
            end else begin
              bitn     <= bitn + 4'd1;
              shreg    <= {1'b1, shreg[FRAME_BITS-1:1]};
              line_out <= shreg[1];
            end
          end else begin
            tick <= tick + BT_W'(1);
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlu_rx.sv
module mlu_rx
  import mlu_pkg::*;
#(
  parameter int BT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            lvl,
  input  logic [BT_W-1:0] bit_ticks,
  output logic [7:0]      rx_byte,
  output logic            rx_valid,
  output logic            frame_err,
  output logic            timeout
);
  rx_state_t             state;
  logic                  lvl_d;
  logic [FRAME_BITS-1:0] bits;
  logic [FRAME_BITS-1:0] filled;
  logic [3:0]            nbits;
  logic [3:0]            idx;
  logic [3:0]            idx_now;
  logic [3:0]            fill_to;
  logic [BT_W-1:0]       rnd;
  logic [BT_W-1:0]       rnd_inc;
  logic                  wrap;
  logic                  edge_seen;
  logic                  at_stop;

  // rnd/idx hold the rounded position one tick back; *_now is this tick
  assign edge_seen = (lvl != lvl_d);
  assign rnd_inc   = rnd + BT_W'(1);
  assign wrap      = (rnd_inc == bit_ticks);
  assign idx_now   = wrap ? idx + 4'd1 : idx;
  assign at_stop   = (idx_now >= 4'(FRAME_BITS));

  always_comb begin
    fill_to = at_stop ? 4'(FRAME_BITS) : idx_now;
    for (int i = 0; i < FRAME_BITS; i++) begin
      filled[i] = (4'(i) >= nbits && 4'(i) < fill_to) ? lvl_d : bits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_WAIT;
      lvl_d     <= 1'b1;
      bits      <= '0;
      nbits     <= '0;
      idx       <= '0;
      rnd       <= '0;
      rx_byte   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      lvl_d     <= lvl;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      timeout   <= 1'b0;
      if (!enable) begin
        state <= RX_WAIT;
      end else begin
        unique case (state)
          RX_WAIT: begin
            if (edge_seen) begin
              if (!lvl) begin
                state <= RX_BYTE;
                bits  <= '0;
                nbits <= 4'd1;
                idx   <= '0;
                rnd   <= bit_ticks >> 1;
              end else begin
                frame_err <= 1'b1;
              end
            end
          end
          RX_BYTE: begin
            idx <= idx_now;
            rnd <= wrap ? '0 : rnd_inc;
            if (at_stop) begin
              state <= RX_WAIT;
              if (filled[STOP_POS]) begin
                rx_valid <= 1'b1;
                rx_byte  <= filled[8:1];
              end else begin
                timeout <= 1'b1;
              end
            end else if (edge_seen) begin
              bits  <= filled;
              nbits <= idx_now;
            end
          end
          default: state <= RX_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/motor_line_uart.sv
module motor_line_uart #(
  parameter int BT_W        = 16,
  parameter int TX_LIMIT    = 100000,
  parameter int GUARD_TICKS = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      tx_data,
  input  logic            tx_start,
  input  logic [BT_W-1:0] bit_ticks,
  input  logic            rx_mode,
  input  logic            line_in,
  output logic            line_out,
  output logic            line_oe,
  output logic            tx_busy,
  output logic            tx_fail,
  output logic [7:0]      rx_byte,
  output logic            rx_valid,
  output logic            rx_frame_err,
  output logic            rx_timeout
);
  logic lvl;

  mlu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(line_in), .dout(lvl)
  );

  mlu_tx #(.BT_W(BT_W), .TX_LIMIT(TX_LIMIT), .GUARD_TICKS(GUARD_TICKS)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .data(tx_data),
    .bit_ticks(bit_ticks), .inhibit(rx_mode),
    .line_out(line_out), .line_oe(line_oe), .busy(tx_busy), .fail(tx_fail)
  );

  mlu_rx #(.BT_W(BT_W)) u_rx (
    .clk(clk), .rst(rst), .enable(rx_mode && !line_oe), .lvl(lvl),
    .bit_ticks(bit_ticks), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .frame_err(rx_frame_err), .timeout(rx_timeout)
  );
endmodule

// File: rtl/motor_line_uart_chk.sv
module motor_line_uart_chk #(
  parameter int BT_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [7:0]      tx_data,
  input logic            tx_start,
  input logic [BT_W-1:0] bit_ticks,
  input logic            rx_mode,
  input logic            line_in,
  input logic            line_out,
  input logic            line_oe,
  input logic            tx_busy,
  input logic            tx_fail,
  input logic [7:0]      rx_byte,
  input logic            rx_valid,
  input logic            rx_frame_err,
  input logic            rx_timeout
);
  AST_BUSY_DRIVES: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> line_oe); // R2

  AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> (line_oe && !line_out)); // R1

  AST_GUARD_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    ($fell(tx_busy) && !tx_fail) |-> (line_oe && line_out)); // R3

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (rst)
    tx_fail |-> (!line_oe && !tx_busy)); // R4

  AST_RX_MODE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && $past(rx_mode) && !$past(line_oe)) |-> !line_oe); // R5

  AST_ONE_RX_EVENT: assert property (@(posedge clk) disable iff (rst)
    $countones({rx_valid, rx_frame_err, rx_timeout}) <= 1); // R6

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    ($past(!rx_mode) || (line_oe && $past(line_oe)))
      |-> !(rx_valid || rx_frame_err || rx_timeout)); // R10

  AST_RELEASED_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> line_out); // R11
endmodule

bind motor_line_uart motor_line_uart_chk #(.BT_W(BT_W)) u_chk (.*);

// File: tb/sim_motor_line_uart.sv
`timescale 1ns/1ps
module sim_motor_line_uart;
  localparam int BT_W  = 16;
  localparam int LIMIT = 3000;
  localparam int GRD   = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [7:0]      tx_data = '0;
  logic            tx_start = 1'b0;
  logic [BT_W-1:0] bit_ticks = 16'd10;
  logic            rx_mode = 1'b0;
  logic            line_in = 1'b1;
  logic            line_out, line_oe, tx_busy, tx_fail;
  logic [7:0]      rx_byte;
  logic            rx_valid, rx_frame_err, rx_timeout;

  int checks = 0;
  int errors = 0;
  int n_valid = 0, n_ferr = 0, n_to = 0;
  logic [7:0] hist [4];
  logic [7:0] last_byte = '0;

  always #10 clk = ~clk;

  motor_line_uart #(.BT_W(BT_W), .TX_LIMIT(LIMIT), .GUARD_TICKS(GRD)) u0 (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_start(tx_start),
    .bit_ticks(bit_ticks), .rx_mode(rx_mode), .line_in(line_in),
    .line_out(line_out), .line_oe(line_oe), .tx_busy(tx_busy), .tx_fail(tx_fail),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_timeout(rx_timeout)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        hist[n_valid % 4] = rx_byte;
        last_byte = rx_byte;
        n_valid++;
      end
      if (rx_frame_err) n_ferr++;
      if (rx_timeout)   n_to++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(line_oe == 1'b0, "R11 line_oe", line_oe, 0);
    chk(line_out == 1'b1, "R11 line_out", line_out, 1);
    chk({tx_busy, tx_fail, rx_valid, rx_frame_err, rx_timeout} == 5'b0, "R11 flags",
        {tx_busy, tx_fail, rx_valid, rx_frame_err, rx_timeout}, 0);
    chk(rx_byte == 8'h00, "R11 rx_byte", rx_byte, 0);
  endtask

  // R1 R2 R3: frame shape, mid-frame start ignored, guard then release
  task automatic t_tx_frame(input logic [7:0] d, input bit poke);
    int bt = int'(bit_ticks);
    logic [9:0] f = {1'b1, d, 1'b0};
    @(negedge clk); tx_data = d; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < bt; c++) begin
        if (poke && k == 3 && c == 0) begin tx_start = 1'b1; tx_data = ~d; end
        else tx_start = 1'b0;
        if (c == bt / 2) begin
          chk(line_out == f[k] && line_oe, poke ? "R2 bit under poke" : "R1 bit level",
              {line_oe, line_out}, {1'b1, f[k]});
          if (k == 5) chk(tx_busy == 1'b1, "R2 busy mid-frame", tx_busy, 1);
        end
        @(negedge clk);
      end
    end
    chk(tx_busy == 1'b0, "R2 busy after stop", tx_busy, 0);
    repeat (GRD - 1) @(negedge clk);
    chk(line_oe && line_out, "R3 guard held", {line_oe, line_out}, 3);
    @(negedge clk);
    chk(line_oe == 1'b0, "R3 released after guard", line_oe, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_tx_guard_restart();
    int bt = int'(bit_ticks);
    @(negedge clk); tx_data = 8'h81; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    repeat (10 * bt + 5) @(negedge clk);
    chk(line_oe && !tx_busy, "R3 in guard", {line_oe, tx_busy}, 2);
    tx_data = 8'h7E; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    chk(tx_busy && line_oe && !line_out, "R3 restart from guard",
        {tx_busy, line_oe, line_out}, 6);
    repeat (10 * bt + GRD + 5) @(negedge clk);
    chk(!line_oe, "R3 idle after second frame", line_oe, 0);
  endtask

  task automatic t_tx_inhibit();
    rx_mode = 1'b1;
    @(negedge clk); tx_data = 8'h55; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    repeat (5) @(negedge clk);
    chk(!line_oe && !tx_busy, "R5 start refused in rx mode", {line_oe, tx_busy}, 0);
    rx_mode = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_tx_limit();
    bit_ticks = 16'd400;
    @(negedge clk); tx_data = 8'hF0; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    repeat (LIMIT - 1) @(negedge clk);
    chk(line_oe && !tx_fail, "R4 still driving before limit", {line_oe, tx_fail}, 2);
    @(negedge clk);
    chk(tx_fail && !line_oe && !tx_busy, "R4 abort at limit",
        {tx_fail, line_oe, tx_busy}, 4);
    @(negedge clk);
    chk(!tx_fail, "R4 fail is one pulse", tx_fail, 0);
    bit_ticks = 16'd10;
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_rx(input logic [7:0] d, input int bt, input int j);
    logic [9:0] f = {1'b1, d, 1'b0};
    for (int k = 0; k < 10; k++) begin
      line_in = f[k];
      repeat (bt + ((k % 2 == 0) ? j : -j)) @(negedge clk);
    end
    line_in = 1'b1;
  endtask

  // R6 R9: decode single frames
  task automatic t_rx_byte(input logic [7:0] d, input int bt, input int j, input string req);
    int bv = n_valid, bf = n_ferr, bto = n_to;
    rx_mode = 1'b1; bit_ticks = BT_W'(bt);
    repeat (3) @(negedge clk);
    drive_rx(d, bt, j);
    repeat (3 * bt) @(negedge clk);
    chk(n_valid == bv + 1, req, n_valid - bv, 1);
    chk(last_byte == d, req, last_byte, d);
    chk(n_ferr == bf && n_to == bto, req, n_ferr - bf + n_to - bto, 0);
  endtask

  task automatic t_rx_back2back();
    int bv = n_valid;
    rx_mode = 1'b1; bit_ticks = 16'd10;
    repeat (3) @(negedge clk);
    drive_rx(8'h3C, 10, 0);
    drive_rx(8'hC3, 10, 0);
    repeat (30) @(negedge clk);
    chk(n_valid == bv + 2, "R6 back-to-back count", n_valid - bv, 2);
    chk(hist[bv % 4] == 8'h3C, "R6 first of pair", hist[bv % 4], 8'h3C);
    chk(hist[(bv + 1) % 4] == 8'hC3, "R6 second of pair", hist[(bv + 1) % 4], 8'hC3);
  endtask

  task automatic t_rx_ignored();
    int bv = n_valid, bf = n_ferr, bto = n_to;
    rx_mode = 1'b0;
    repeat (3) @(negedge clk);
    drive_rx(8'h5A, 10, 0);
    line_in = 1'b0; repeat (15) @(negedge clk);
    line_in = 1'b1; repeat (30) @(negedge clk);
    chk(n_valid == bv && n_ferr == bf && n_to == bto, "R10 no events with rx off",
        n_valid - bv + n_ferr - bf + n_to - bto, 0);
    chk(rx_byte == last_byte, "R10 rx_byte unchanged", rx_byte, last_byte);
  endtask

  task automatic t_rx_frame_err();
    int bv = n_valid, bf = n_ferr;
    rx_mode = 1'b0; line_in = 1'b0;
    repeat (5) @(negedge clk);
    rx_mode = 1'b1;
    repeat (5) @(negedge clk);
    line_in = 1'b1;
    repeat (8) @(negedge clk);
    chk(n_ferr == bf + 1, "R7 framing error pulse", n_ferr - bf, 1);
    chk(n_valid == bv, "R7 no byte", n_valid - bv, 0);
  endtask

  task automatic t_rx_timeout();
    int bv = n_valid, bto = n_to;
    rx_mode = 1'b1; bit_ticks = 16'd10; line_in = 1'b1;
    repeat (5) @(negedge clk);
    line_in = 1'b0;
    repeat (120) @(negedge clk);
    chk(n_to == bto + 1, "R8 timeout pulse", n_to - bto, 1);
    chk(n_valid == bv, "R8 no byte", n_valid - bv, 0);
    line_in = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_frame(8'hA5, 1'b0);
    t_tx_frame(8'h0F, 1'b1);
    t_tx_guard_restart();
    t_tx_inhibit();
    t_tx_limit();
    t_rx_byte(8'hA5, 10, 0, "R6 decode A5");
    t_rx_byte(8'h00, 10, 0, "R6 decode 00");
    t_rx_byte(8'hFF, 10, 0, "R6 decode FF");
    t_rx_byte(8'h96, 12, 3, "R9 displaced edges 96");
    t_rx_byte(8'h3B, 16, 7, "R9 displaced edges 3B");
    t_rx_back2back();
    t_rx_ignored();
    t_rx_frame_err();
    t_rx_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule